// File: doc/BRIEF.md
# Banked Shadow Register File

This block is a general-purpose register file made of several complete banks. Each bank holds thirty-two 32-bit registers. A registered active-set index chooses the bank that ordinary instructions use. Two combinational operand read ports and one synchronous result write port always address the active bank. A separate cross-bank path can read from, or write to, the bank named by a second input, the previous-set index. A context-switch sequence can therefore move values between register sets without first changing the active set.

The number of banks is a parameter. The index inputs are six bits wide, so up to 64 banks can be addressed. An index that names a bank the instance does not have is redirected to bank 0 and raises an error flag. Register contents are not cleared by reset; only the active-set index is. An optional bypass parameter selects whether a read that collides with a same-cycle write returns the stored value or the value being written.

The block has no state machine. Its only sequential state is the active-set register and the bank storage, and both update on every rising clock edge.

Top module: `shadow_regfile`

## Requirements
- R1: A write with its enable high stores the 32-bit data into the addressed register at the rising clock edge. The new value appears on the combinational read ports after that edge.
- R2: Register 0 of every bank reads as zero on every read port. Writes to register 0 are discarded.
- R3: The active-set index is 0 after reset. It loads `cur_set_i` at a rising edge when `cur_set_ld` is high and holds otherwise. Both operand reads and the normal write touch only the bank it selects.
- R4: The cross-bank read returns the register `xb_rd_addr` of the bank named by `prv_set_i`. It is combinational. When `xb_rd_en` is low, `xb_rd_data` is zero.
- R5: A cross-bank write stores `xb_wr_data` into register `xb_wr_addr` of the bank named by `prv_set_i`. Every other bank and register keeps its value.
- R6: When the normal write and the cross-bank write hit the same register of the same bank in one cycle, the normal write's data is kept.
- R7: With `BYPASS` = 0, a read of a register that is being written in the same cycle returns the old contents. With `BYPASS` = 1, it returns the data being written. A write to register 0 is never bypassed.
- R8: An index at or above `NUM_BANKS` selects bank 0. `bank_err_o` is high while the active-set index is out of range. It is also high while `prv_set_i` is out of range and either cross-bank enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the active-set index |
| cur_set_ld | input | 1 | Load strobe for the active-set index |
| cur_set_i | input | 6 | New active-set index |
| prv_set_i | input | 6 | Bank index for the cross-bank operations |
| rd_a_addr | input | 5 | Operand A register number |
| rd_a_data | output | 32 | Operand A data from the active bank |
| rd_b_addr | input | 5 | Operand B register number |
| rd_b_data | output | 32 | Operand B data from the active bank |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 5 | Normal write register number |
| wr_data | input | 32 | Normal write data |
| xb_rd_en | input | 1 | Cross-bank read enable |
| xb_rd_addr | input | 5 | Cross-bank read register number |
| xb_rd_data | output | 32 | Cross-bank read data, zero when disabled |
| xb_wr_en | input | 1 | Cross-bank write enable |
| xb_wr_addr | input | 5 | Cross-bank write register number |
| xb_wr_data | input | 32 | Cross-bank write data |
| bank_err_o | output | 1 | An index in use is out of range |

## Verification
The hardest situation to reach is a single cycle in which the normal write, the cross-bank write and the reads all land on one register of one bank. It only arises when the previous-set index equals the active one.

The stimulus first gives every register of every bank a distinct value. It then loads the active set with the same index it drives on the previous-set input. In that cycle it issues both writes and reads the same register, so both the write priority and the old-versus-new read value can be seen.

A second instance built with bypass enabled receives identical stimulus. Its read results in the colliding cycle are compared against the instance without bypass.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // Read port numbering inside every bank.
    localparam int SRF_NUM_RD = 3;
    localparam int SRF_RD_A   = 0;
    localparam int SRF_RD_B   = 1;
    localparam int SRF_RD_X   = 2;

    // Which pending write, if any, feeds a read port in the same cycle.
    typedef enum logic [1:0] {
        BYP_NONE = 2'd0,
        BYP_ACT  = 2'd1,
        BYP_XB   = 2'd2
    } byp_src_e;

endpackage

// File: rtl/srf_set_reg.sv
module srf_set_reg #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [IDX_W-1:0] set_i,
    output logic [IDX_W-1:0] set_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (ld) begin
            set_q <= set_i;
        end
    end

    // R3
    set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (set_q == $past(set_i)));

    // R3
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(set_q));

endmodule

// File: rtl/srf_bank_decode.sv
module srf_bank_decode #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 6,
    parameter int BANK_W    = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BANK_W-1:0] bank,
    output logic              bad
);

    always_comb begin
        bad  = (32'(idx) >= 32'(NUM_BANKS));
        bank = bad ? '0 : BANK_W'(idx);
    end

endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 3,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0,
    input  logic [AW-1:0]     wa0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [AW-1:0]     wa1,
    input  logic [DATA_W-1:0] wd1,
    input  logic [AW-1:0]     raddr [NUM_RD],
    output logic [DATA_W-1:0] rdata [NUM_RD]
);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              wr0_ok;
    logic              wr1_ok;

    always_comb begin
        wr0_ok = we0 && (wa0 != '0);
        // Port 0 wins a same-register collision.
        wr1_ok = we1 && (wa1 != '0) && !(wr0_ok && (wa0 == wa1));
    end

    always_ff @(posedge clk) begin
        regs[0] <= '0;
        if (wr0_ok) begin
            regs[wa0] <= wd0;
        end
        if (wr1_ok) begin
            regs[wa1] <= wd1;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

    // R1
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && (wa0 != '0)) |=> (regs[$past(wa0)] == $past(wd0)));

    // R6
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && we1 && (wa0 == wa1) && (wa0 != '0)) |=> (regs[$past(wa1)] == $past(wd0)));

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 6,
    parameter bit BYPASS    = 1'b0,
    localparam int AW       = $clog2(NUM_REGS),
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_set_ld,
    input  logic [IDX_W-1:0]  cur_set_i,
    input  logic [IDX_W-1:0]  prv_set_i,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xb_rd_en,
    input  logic [AW-1:0]     xb_rd_addr,
    output logic [DATA_W-1:0] xb_rd_data,
    input  logic              xb_wr_en,
    input  logic [AW-1:0]     xb_wr_addr,
    input  logic [DATA_W-1:0] xb_wr_data,
    output logic              bank_err_o
);

    import srf_pkg::*;

    logic [IDX_W-1:0]  act_raw;
    logic [BANK_W-1:0] act_bank;
    logic [BANK_W-1:0] prv_bank;
    logic              act_bad;
    logic              prv_bad;

    logic [AW-1:0]     port_addr [SRF_NUM_RD];
    logic [BANK_W-1:0] port_bank [SRF_NUM_RD];
    logic [DATA_W-1:0] port_data [SRF_NUM_RD];
    logic [DATA_W-1:0] bank_rd   [NUM_BANKS][SRF_NUM_RD];

    srf_set_reg #(.IDX_W(IDX_W)) u_set (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (cur_set_ld),
        .set_i (cur_set_i),
        .set_q (act_raw)
    );

    srf_bank_decode #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_dec_act (
        .idx  (act_raw),
        .bank (act_bank),
        .bad  (act_bad)
    );

    srf_bank_decode #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_dec_prv (
        .idx  (prv_set_i),
        .bank (prv_bank),
        .bad  (prv_bad)
    );

    assign bank_err_o = act_bad || (prv_bad && (xb_rd_en || xb_wr_en));

    always_comb begin
        port_addr[SRF_RD_A] = rd_a_addr;
        port_addr[SRF_RD_B] = rd_b_addr;
        port_addr[SRF_RD_X] = xb_rd_addr;
        port_bank[SRF_RD_A] = act_bank;
        port_bank[SRF_RD_B] = act_bank;
        port_bank[SRF_RD_X] = prv_bank;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic we_act;
        logic we_xb;

        assign we_act = wr_en    && (act_bank == BANK_W'(g));
        assign we_xb  = xb_wr_en && (prv_bank == BANK_W'(g));

        srf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(SRF_NUM_RD)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we0   (we_act),
            .wa0   (wr_addr),
            .wd0   (wr_data),
            .we1   (we_xb),
            .wa1   (xb_wr_addr),
            .wd1   (xb_wr_data),
            .raddr (port_addr),
            .rdata (bank_rd[g])
        );
    end

    for (genvar p = 0; p < SRF_NUM_RD; p++) begin : g_port
        logic [DATA_W-1:0] stored;
        byp_src_e          src;

        assign stored = bank_rd[port_bank[p]][p];

        if (BYPASS) begin : g_byp
            always_comb begin
                src = BYP_NONE;
                if (port_addr[p] != '0) begin
                    if (wr_en && (act_bank == port_bank[p]) && (wr_addr == port_addr[p])) begin
                        src = BYP_ACT;
                    end else if (xb_wr_en && (prv_bank == port_bank[p])
                                 && (xb_wr_addr == port_addr[p])) begin
                        src = BYP_XB;
                    end
                end
            end
        end else begin : g_nobyp
            assign src = BYP_NONE;
        end

        always_comb begin
            unique case (src)
                BYP_ACT: port_data[p] = wr_data;
                BYP_XB:  port_data[p] = xb_wr_data;
                default: port_data[p] = stored;
            endcase
        end
    end

    assign rd_a_data  = port_data[SRF_RD_A];
    assign rd_b_data  = port_data[SRF_RD_B];
    assign xb_rd_data = xb_rd_en ? port_data[SRF_RD_X] : '0;

    // R2
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    // R2
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    // R8
    act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(act_raw) >= 32'(NUM_BANKS)) |-> bank_err_o);

    // R4
    xb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xb_rd_en |-> (xb_rd_data == '0));

endmodule

// File: tb/sim_shadow_regfile.sv
`timescale 1ns/1ps
module sim_shadow_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cur_set_ld;
    logic [5:0]  cur_set_i;
    logic [5:0]  prv_set_i;
    logic [4:0]  rd_a_addr, rd_b_addr, wr_addr, xb_rd_addr, xb_wr_addr;
    logic [31:0] wr_data, xb_wr_data;
    logic        wr_en, xb_rd_en, xb_wr_en;
    logic [31:0] a0, b0, x0, a1, b1, x1;
    logic        err0, err1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shadow_regfile #(.BYPASS(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_set_ld(cur_set_ld), .cur_set_i(cur_set_i),
        .prv_set_i(prv_set_i), .rd_a_addr(rd_a_addr), .rd_a_data(a0),
        .rd_b_addr(rd_b_addr), .rd_b_data(b0), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .xb_rd_en(xb_rd_en), .xb_rd_addr(xb_rd_addr),
        .xb_rd_data(x0), .xb_wr_en(xb_wr_en), .xb_wr_addr(xb_wr_addr),
        .xb_wr_data(xb_wr_data), .bank_err_o(err0));

    shadow_regfile #(.BYPASS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cur_set_ld(cur_set_ld), .cur_set_i(cur_set_i),
        .prv_set_i(prv_set_i), .rd_a_addr(rd_a_addr), .rd_a_data(a1),
        .rd_b_addr(rd_b_addr), .rd_b_data(b1), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .xb_rd_en(xb_rd_en), .xb_rd_addr(xb_rd_addr),
        .xb_rd_data(x1), .xb_wr_en(xb_wr_en), .xb_wr_addr(xb_wr_addr),
        .xb_wr_data(xb_wr_data), .bank_err_o(err1));

    typedef struct packed {
        logic [7:0]  req;
        logic        ld;
        logic [5:0]  set;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        xe;
        logic [4:0]  xa;
        logic [31:0] xd;
        logic [5:0]  prv;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [4:0]  xra;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] ex;
    } vec_t;

    // Start state: bank b register r holds 0x5A000000 + b*256 + r; active set 0.
    // Expected values are the outputs sampled before the edge that commits the vector.
    localparam vec_t VECS [11] = '{
        // R4 plain reads on active bank 0 and cross read of bank 2
        '{8'd4, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd2, 5'd5, 5'd31, 5'd7,
          32'h5A000005, 32'h5A00001F, 32'h5A000207},
        // R7 write r5 while reading it: old value; R2 read r0
        '{8'd7, 1'b0, 6'd0, 1'b1, 5'd5, 32'h11111111, 1'b0, 5'd0, 32'h0, 6'd1, 5'd5, 5'd0, 5'd3,
          32'h5A000005, 32'h0, 32'h5A000103},
        // R1 new r5 visible; R5 cross write bank 3 r9, cross read sees old
        '{8'd1, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd9, 32'h33333333, 6'd3, 5'd5, 5'd9, 5'd9,
          32'h11111111, 32'h5A000009, 32'h5A000309},
        // R5 cross write landed; R2 write to r0
        '{8'd5, 1'b0, 6'd0, 1'b1, 5'd0, 32'hFFFFFFFF, 1'b0, 5'd0, 32'h0, 6'd3, 5'd9, 5'd0, 5'd9,
          32'h5A000009, 32'h0, 32'h33333333},
        // R2 r0 still zero; R3 load set 2, reads still on bank 0 this cycle
        '{8'd2, 1'b1, 6'd2, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd0, 5'd0, 5'd1, 5'd5,
          32'h0, 32'h5A000001, 32'h11111111},
        // R6 normal and cross write collide on bank 2 r7
        '{8'd6, 1'b0, 6'd0, 1'b1, 5'd7, 32'h22222222, 1'b1, 5'd7, 32'hDEADBEEF, 6'd2, 5'd7, 5'd5, 5'd7,
          32'h5A000207, 32'h5A000205, 32'h5A000207},
        // R6 normal data kept
        '{8'd6, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd2, 5'd7, 5'd6, 5'd7,
          32'h22222222, 32'h5A000206, 32'h22222222},
        // R3 reads on bank 2, load set 0
        '{8'd3, 1'b1, 6'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd3, 5'd1, 5'd9, 5'd9,
          32'h5A000201, 32'h5A000209, 32'h33333333},
        // R3 bank 0 untouched by the bank 2 writes
        '{8'd3, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd2, 5'd5, 5'd7, 5'd7,
          32'h11111111, 32'h5A000007, 32'h22222222},
        // R5 cross write bank 1 r4 from active bank 0
        '{8'd5, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b1, 5'd4, 32'h44444444, 6'd1, 5'd4, 5'd31, 5'd4,
          32'h5A000004, 32'h5A00001F, 32'h5A000104},
        // R5 only bank 1 r4 changed
        '{8'd5, 1'b0, 6'd0, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0, 6'd1, 5'd4, 5'd31, 5'd4,
          32'h5A000004, 32'h5A00001F, 32'h44444444}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cur_set_ld = 1'b0; cur_set_i = '0; prv_set_i = '0;
        rd_a_addr = '0; rd_b_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        xb_rd_en = 1'b1; xb_rd_addr = '0; xb_wr_en = 1'b0; xb_wr_addr = '0; xb_wr_data = '0;
    endtask

    task automatic chk(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R0 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state: register 0 zero; R8 no error with active index 0
        chk("reset r0 read", 2, a0, 32'h0);
        chk("reset error flag", 8, {31'b0, err0}, 32'h0);
        @(negedge clk);

        // Fill every register of every bank through the normal port.
        for (int b = 0; b < 4; b++) begin
            cur_set_ld = 1'b1; cur_set_i = 6'(b);
            step();
            cur_set_ld = 1'b0;
            for (int r = 1; r < 32; r++) begin
                wr_en = 1'b1; wr_addr = 5'(r); wr_data = 32'h5A000000 + 32'(b * 256 + r);
                step();
            end
            wr_en = 1'b0;
        end
        cur_set_ld = 1'b1; cur_set_i = 6'd0;
        step();
        idle();

        for (int i = 0; i < 11; i++) begin
            cur_set_ld = VECS[i].ld;  cur_set_i = VECS[i].set;
            wr_en      = VECS[i].we;  wr_addr   = VECS[i].wa;  wr_data    = VECS[i].wd;
            xb_wr_en   = VECS[i].xe;  xb_wr_addr = VECS[i].xa; xb_wr_data = VECS[i].xd;
            prv_set_i  = VECS[i].prv; rd_a_addr = VECS[i].ra;  rd_b_addr  = VECS[i].rb;
            xb_rd_addr = VECS[i].xra; xb_rd_en  = 1'b1;
            #1;
            chk($sformatf("vector %0d port A", i), int'(VECS[i].req), a0, VECS[i].ea);
            chk($sformatf("vector %0d port B", i), int'(VECS[i].req), b0, VECS[i].eb);
            chk($sformatf("vector %0d cross", i),  int'(VECS[i].req), x0, VECS[i].ex);
            step();
        end
        idle();

        // R7 collision: no-bypass instance returns old, bypass instance new
        wr_en = 1'b1; wr_addr = 5'd10; wr_data = 32'h77777777; rd_a_addr = 5'd10;
        xb_wr_en = 1'b1; prv_set_i = 6'd1; xb_wr_addr = 5'd11; xb_wr_data = 32'h88888888;
        xb_rd_addr = 5'd11;
        #1;
        chk("no bypass port A", 7, a0, 32'h5A00000A);
        chk("bypass port A", 7, a1, 32'h77777777);
        chk("no bypass cross", 7, x0, 32'h5A00010B);
        chk("bypass cross", 7, x1, 32'h88888888);
        step();
        idle();
        rd_a_addr = 5'd10; prv_set_i = 6'd1; xb_rd_addr = 5'd11;
        #1;
        chk("write visible next cycle", 1, a0, 32'h77777777);
        chk("cross write visible", 5, x0, 32'h88888888);
        @(negedge clk);
        // R7 and R2: write to r0 is never bypassed
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hFFFFFFFF; rd_a_addr = 5'd0;
        #1;
        chk("bypass of r0", 2, a1, 32'h0);
        step();
        idle();

        // R8 active index out of range maps to bank 0
        cur_set_ld = 1'b1; cur_set_i = 6'd5;
        step();
        idle();
        rd_a_addr = 5'd2;
        #1;
        chk("active out of range flag", 8, {31'b0, err0}, 32'h1);
        chk("active out of range bank 0", 8, a0, 32'h5A000002);
        @(negedge clk);
        cur_set_ld = 1'b1; cur_set_i = 6'd1;
        step();
        idle();
        prv_set_i = 6'd63; xb_rd_en = 1'b1; xb_rd_addr = 5'd2; rd_a_addr = 5'd2;
        #1;
        chk("cross out of range flag", 8, {31'b0, err0}, 32'h1);
        chk("cross out of range bank 0", 8, x0, 32'h5A000002);
        chk("active bank 1 read", 3, a0, 32'h5A000102);
        @(negedge clk);
        xb_rd_en = 1'b0;
        #1;
        chk("unused cross index no flag", 8, {31'b0, err0}, 32'h0);
        chk("cross read disabled", 4, x0, 32'h0);
        @(negedge clk);
        idle();

        // R3 reset returns the active set to 0 but keeps contents
        cur_set_ld = 1'b1; cur_set_i = 6'd3;
        step();
        idle();
        rd_a_addr = 5'd2;
        #1;
        chk("active bank 3 read", 3, a0, 32'h5A000302);
        @(negedge clk);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        #1;
        chk("active set after reset", 3, a0, 32'h5A000002);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule